// File: doc/BRIEF.md
# HDLC Per-Frame Status Queue

This block keeps a short queue of per-frame results beside a bit-oriented (HDLC-style) receiver. Each time the receiver closes a frame, the block stores one entry: the frame's byte count and the error and residue status bits captured at that moment. The receiver closes a frame either with an end-of-frame strobe or with an abort strobe. A DMA engine can then move the data of several back-to-back frames into memory, and software checks each frame's length and errors later, oldest first.

Software sees the queue through three byte-wide read selections: a count-high byte that also carries two flags, a count-low byte, and the receive status byte. The intended order is count-high, then count-low (optional), then status. Reading the status selection retires the oldest entry. The queue is active only when its enable bit is set and the channel runs in bit-oriented mode. In every other case the reads fall through to live registers and the queue is held empty.

Top module: `frame_status_queue`

## Requirements
- R1: Up to DEPTH (default 10) closed frames are held, and they are returned oldest first. Each entry holds a 14-bit byte count and 5 status bits.
- R2: The stored byte count equals the number of cycles with `rx_byte_stb` high since the previous frame close, counting a strobe in the closing cycle itself, modulo 2^14. The running count restarts from zero after every end-of-frame or abort strobe.
- R3: An abort strobe closes the frame exactly like an end-of-frame strobe. It stores the count and status and restarts the count.
- R4: The queue is active only when `cfg_enable` and `cfg_bitsync` are both 1. While inactive, selection 0 returns `live_stat`, selection 1 returns `mirror_lo` and selection 2 returns `mirror_hi`.
- R5: While inactive, and after reset, the queue is empty and the overflow flag is 0. After reset, `rd_data` is 0.
- R6: Selection 2 (count-high) returns bit 7 = overflow flag, bit 6 = queue not empty, and bits 5:0 = count bits 13:8 of the oldest entry. Selection 1 (count-low) returns count bits 7:0 of the oldest entry. While the queue is active and empty, both count fields read 0.
- R7: When the queue is active and holds an entry, selection 0 (status) returns bits 6, 5, 3, 2, 1 from the oldest entry, as captured from `live_stat` when the frame closed. Bits 7, 4 and 0 come from the current `live_stat`. This read removes that entry. When the queue is active and empty, selection 0 returns `live_stat`.
- R8: A status read while the queue is empty changes nothing. A frame closed afterwards is returned normally.
- R9: A frame closed while DEPTH entries are held, with no status read in that cycle, is discarded and sets the overflow flag. The flag stays 1 until the queue becomes inactive.
- R10: `rd_data` is registered. It takes the selected value in the cycle after `rd_stb` and holds that value while `rd_stb` is low. Selection 3 reads 0.
- R11: A frame closed while the queue is full, in the same cycle as a status read, is stored, and the overflow flag stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Queue enable bit |
| cfg_bitsync | input | 1 | Channel is in bit-oriented frame mode |
| rx_byte_stb | input | 1 | One received byte of the current frame |
| rx_eof_stb | input | 1 | Current frame ended normally |
| rx_abort_stb | input | 1 | Current frame ended by abort |
| live_stat | input | 8 | Live receive status byte |
| mirror_lo | input | 8 | Byte returned by selection 1 while inactive |
| mirror_hi | input | 8 | Byte returned by selection 2 while inactive |
| rd_stb | input | 1 | Register read strobe |
| rd_sel | input | 2 | 0 status, 1 count-low, 2 count-high, 3 none |
| rd_data | output | 8 | Registered read data |

## Verification
The checker watches the following on every cycle:
- occupancy never exceeds DEPTH and is zero in the cycle after the queue is inactive;
- a status read of an empty queue leaves occupancy at zero;
- a closing frame against a full queue sets the overflow flag, and the flag persists while the queue is active;
- the count-high availability bit matches the occupancy;
- `rd_data` holds its value between read strobes.

Only the bench scenarios can show that the right count and the right status bits come back, and in arrival order. The same holds for aborts behaving like normal closes and for counter wrap. It also covers the simultaneous read-and-close on a full queue, and the bypass values returned when the enable bit or the mode flag is dropped.

// File: rtl/frame_status_pkg.sv
package frame_status_pkg;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned QBITS  = 5;

  // bits 6,5 (CRC, overrun) and 3..1 (residue) are queued
  localparam logic [STAT_W-1:0] QUEUED_MASK = 8'h6E;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CNT_LO = 2'd1,
    SEL_CNT_HI = 2'd2,
    SEL_NONE   = 2'd3
  } rd_sel_e;

  function automatic logic [QBITS-1:0] pack_status(input logic [STAT_W-1:0] s);
    return {s[6], s[5], s[3], s[2], s[1]};
  endfunction

  function automatic logic [STAT_W-1:0] unpack_status(input logic [QBITS-1:0] q);
    logic [STAT_W-1:0] r;
    r    = '0;
    r[6] = q[4];
    r[5] = q[3];
    r[3] = q[2];
    r[2] = q[1];
    r[1] = q[0];
    return r;
  endfunction

endpackage

// File: rtl/frame_byte_counter.sv
module frame_byte_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_stb,
  input  logic             close_stb,
  output logic [CNT_W-1:0] frame_len
);
  logic [CNT_W-1:0] count_q;

  // length of the frame closing this cycle includes a same-cycle byte
  assign frame_len = count_q + CNT_W'(byte_stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (close_stb) begin
      count_q <= '0;
    end else if (byte_stb) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/frame_entry_store.sv
module frame_entry_store #(
  parameter int unsigned DEPTH   = 10,
  parameter int unsigned ENTRY_W = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop_req,
  output logic [ENTRY_W-1:0] head_data,
  output logic               avail,
  output logic               ovf,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic               full, pop, wr_en;

  assign full  = (occ == FULL_OCC);
  assign avail = (occ != '0);
  assign pop   = active && pop_req && avail;
  assign wr_en = active && push && (!full || pop);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (pop)   rd_ptr <= bump(rd_ptr);
      if (wr_en && !pop)      occ <= occ + 1'b1;
      else if (pop && !wr_en) occ <= occ - 1'b1;
      if (push && full && !pop) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_read_port.sv
module frame_read_port
  import frame_status_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rd_stb,
  input  logic [1:0]        rd_sel,
  input  logic [CNT_W-1:0]  head_cnt,
  input  logic [QBITS-1:0]  head_stat,
  input  logic              avail,
  input  logic              ovf,
  input  logic [STAT_W-1:0] live_stat,
  input  logic [STAT_W-1:0] mirror_lo,
  input  logic [STAT_W-1:0] mirror_hi,
  output logic              pop_req,
  output logic [STAT_W-1:0] rd_data
);
  localparam int unsigned HI_W = 6;

  logic [CNT_W-1:0]  cnt_shown;
  logic [HI_W-1:0]   hi_field;
  logic [STAT_W-1:0] stat_val, lo_val, hi_val, nxt;

  assign pop_req   = active && rd_stb && (rd_sel == SEL_STATUS);
  assign cnt_shown = avail ? head_cnt : '0;
  assign hi_field  = HI_W'(cnt_shown >> 8);

  always_comb begin
    if (!active) begin
      stat_val = live_stat;
      lo_val   = mirror_lo;
      hi_val   = mirror_hi;
    end else begin
      stat_val = avail ? ((live_stat & ~QUEUED_MASK) | unpack_status(head_stat)) : live_stat;
      lo_val   = cnt_shown[7:0];
      hi_val   = {ovf, avail, hi_field};
    end
    case (rd_sel)
      SEL_STATUS: nxt = stat_val;
      SEL_CNT_LO: nxt = lo_val;
      SEL_CNT_HI: nxt = hi_val;
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= nxt;
  end
endmodule

// File: rtl/frame_status_queue.sv
module frame_status_queue
  import frame_status_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned CNT_W = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_enable,
  input  logic        cfg_bitsync,
  input  logic        rx_byte_stb,
  input  logic        rx_eof_stb,
  input  logic        rx_abort_stb,
  input  logic [7:0]  live_stat,
  input  logic [7:0]  mirror_lo,
  input  logic [7:0]  mirror_hi,
  input  logic        rd_stb,
  input  logic [1:0]  rd_sel,
  output logic [7:0]  rd_data
);
  localparam int unsigned ENTRY_W = CNT_W + QBITS;
  localparam int unsigned OCC_W   = $clog2(DEPTH+1);

  logic               active, close_stb, pop_req, avail, ovf;
  logic [CNT_W-1:0]   frame_len;
  logic [ENTRY_W-1:0] push_data, head_data;
  logic [OCC_W-1:0]   occ_w;

  assign active    = cfg_enable && cfg_bitsync;
  assign close_stb = rx_eof_stb || rx_abort_stb;
  assign push_data = {pack_status(live_stat), frame_len};

  frame_byte_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .byte_stb(rx_byte_stb),
    .close_stb(close_stb), .frame_len(frame_len)
  );

  frame_entry_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst(rst), .active(active), .push(close_stb),
    .push_data(push_data), .pop_req(pop_req), .head_data(head_data),
    .avail(avail), .ovf(ovf), .occ(occ_w)
  );

  frame_read_port #(.CNT_W(CNT_W)) u_read (
    .clk(clk), .rst(rst), .active(active), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .head_cnt(head_data[CNT_W-1:0]), .head_stat(head_data[ENTRY_W-1:CNT_W]),
    .avail(avail), .ovf(ovf), .live_stat(live_stat),
    .mirror_lo(mirror_lo), .mirror_hi(mirror_hi),
    .pop_req(pop_req), .rd_data(rd_data)
  );
endmodule

// File: rtl/frame_status_queue_checker.sv
module frame_status_queue_checker #(
  parameter int unsigned DEPTH = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       active,
  input logic                       close_stb,
  input logic                       pop_req,
  input logic [$clog2(DEPTH+1)-1:0] occ,
  input logic                       ovf,
  input logic                       rd_stb,
  input logic [1:0]                 rd_sel,
  input logic [7:0]                 rd_data
);
  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (rst)
    occ <= ($clog2(DEPTH+1))'(DEPTH));

  assert_inactive_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !active |=> (occ == '0) && !ovf);

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (pop_req && occ == '0 && !close_stb) |=> occ == '0);

  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (rst)
    (active && close_stb && !pop_req && occ == ($clog2(DEPTH+1))'(DEPTH)) |=> ovf);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf && active) |=> ovf);

  assert_avail_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (active && rd_stb && rd_sel == 2'd2) |=> rd_data[6] == ($past(occ) != '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
endmodule

bind frame_status_queue frame_status_queue_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .active(active), .close_stb(close_stb),
  .pop_req(pop_req), .occ(occ_w), .ovf(ovf), .rd_stb(rd_stb),
  .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/frame_status_queue_tb.sv
module frame_status_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 10;
  localparam logic [7:0] QM = 8'h6E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, md = 1'b0;
  logic b_stb = 1'b0, e_stb = 1'b0, a_stb = 1'b0, r_stb = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] ls = 8'h00, lo = 8'h00, hi = 8'h00;
  logic [7:0] rd_data;

  int vectors = 0;
  int errors = 0;

  logic [18:0] mq[$];
  logic [13:0] mcnt = '0;
  logic        movf = 1'b0;
  logic [7:0]  last_rd = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_status_queue dut_i (
    .clk(clk), .rst(rst), .cfg_enable(en), .cfg_bitsync(md),
    .rx_byte_stb(b_stb), .rx_eof_stb(e_stb), .rx_abort_stb(a_stb),
    .live_stat(ls), .mirror_lo(lo), .mirror_hi(hi),
    .rd_stb(r_stb), .rd_sel(sel), .rd_data(rd_data)
  );

  function automatic logic [7:0] unq(input logic [4:0] q);
    logic [7:0] r;
    r = '0;
    r[6] = q[4]; r[5] = q[3]; r[3] = q[2]; r[2] = q[1]; r[1] = q[0];
    return r;
  endfunction

  function automatic logic [7:0] expect_read(input logic act, input logic [1:0] s,
                                             input logic [7:0] l, input logic [7:0] ml,
                                             input logic [7:0] mh);
    logic ne;
    logic [13:0] c;
    ne = (mq.size() != 0);
    c  = ne ? mq[0][13:0] : 14'd0;
    case (s)
      2'd0: return (act && ne) ? ((l & ~QM) | unq(mq[0][18:14])) : l;
      2'd1: return act ? c[7:0] : ml;
      2'd2: return act ? {movf, ne, c[13:8]} : mh;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: rd_data actual %02h expected %02h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic step(input logic b, input logic e, input logic a, input logic r,
                      input logic [1:0] s, input logic [7:0] l, input string tag);
    logic act, pop, push;
    logic [13:0] flen;
    string t;
    b_stb = b; e_stb = e; a_stb = a; r_stb = r; sel = s; ls = l;
    act = en && md;
    if (r) last_rd = expect_read(act, s, l, lo, hi);
    flen = mcnt + 14'(b);
    pop  = act && r && (s == 2'd0) && (mq.size() != 0);
    push = act && (e || a);
    if (!act) begin
      mq.delete();
      movf = 1'b0;
    end else begin
      if (pop) void'(mq.pop_front());
      if (push) begin
        if (mq.size() < DEPTH) mq.push_back({l[6], l[5], l[3], l[2], l[1], flen});
        else movf = 1'b1;
      end
    end
    if (e || a) mcnt = '0;
    else mcnt = flen;
    @(posedge clk);
    @(negedge clk);
    if (tag != "") t = tag;
    else if (!r) t = "R10";
    else if (!act) t = "R4";
    else if (s == 2'd0) t = "R7";
    else if (s == 2'd3) t = "R10";
    else t = "R6";
    check(t, rd_data, last_rd);
    b_stb = 0; e_stb = 0; a_stb = 0; r_stb = 0;
  endtask

  task automatic frame(input int nbytes, input logic [7:0] st, input logic ab, input string tag);
    for (int i = 0; i < nbytes; i++) step(1, 0, 0, 0, 0, 8'h00, tag);
    step(0, !ab, ab, 0, 0, st, tag);
  endtask

  task automatic read3(input logic [7:0] l, input string tag);
    step(0, 0, 0, 1, 2'd2, l, tag);
    step(0, 0, 0, 1, 2'd1, l, tag);
    step(0, 0, 0, 1, 2'd0, l, tag);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5", rd_data, 8'h00);

    // inactive bypass after reset
    lo = 8'hA5; hi = 8'h3C;
    step(0, 0, 0, 1, 2'd0, 8'h91, "R4");
    step(0, 0, 0, 1, 2'd1, 8'h91, "R4");
    step(0, 0, 0, 1, 2'd2, 8'h91, "R4");
    step(0, 0, 0, 1, 2'd3, 8'h91, "R10");
    frame(4, 8'hFF, 0, "R5");

    // active: ordered frames, abort and count
    en = 1; md = 1;
    step(0, 0, 0, 1, 2'd2, 8'h00, "R5");
    frame(5, 8'h6E, 0, "R2");
    frame(0, 8'h20, 0, "R2");
    frame(300, 8'h0A, 1, "R3");
    read3(8'h91, "R1");
    read3(8'h00, "R1");
    read3(8'hFF, "R3");

    // empty pop
    step(0, 0, 0, 1, 2'd0, 8'h55, "R8");
    step(0, 0, 0, 1, 2'd0, 8'hAA, "R8");
    frame(7, 8'h44, 0, "R8");
    read3(8'h00, "R8");

    // overflow and stickiness
    for (int k = 0; k < 11; k++) frame(k + 1, 8'(k * 37), 0, "R9");
    step(0, 0, 0, 1, 2'd2, 8'h00, "R9");
    for (int k = 0; k < 10; k++) read3(8'h81, "R9");
    step(0, 0, 0, 1, 2'd2, 8'h00, "R9");
    en = 0;
    step(0, 0, 0, 0, 0, 8'h00, "R5");
    en = 1;
    step(0, 0, 0, 1, 2'd2, 8'h00, "R9");

    // full with simultaneous pop and push
    for (int k = 0; k < 10; k++) frame(2, 8'h02, 0, "R11");
    step(1, 1, 0, 1, 2'd0, 8'h6E, "R11");
    step(0, 0, 0, 1, 2'd2, 8'h00, "R11");
    for (int k = 0; k < 10; k++) read3(8'h00, "R11");

    // mode flag dropped
    frame(3, 8'h08, 0, "R4");
    md = 0;
    read3(8'h33, "R4");
    md = 1;
    step(0, 0, 0, 1, 2'd2, 8'h00, "R5");

    // counter wrap
    frame(16384 + 3, 8'h00, 0, "R2");
    read3(8'h00, "R2");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic rb, re, ra, rr;
      logic [1:0] rs;
      if (($urandom % 200) == 0) en = ~en;
      if (($urandom % 400) == 0) md = ~md;
      lo = 8'($urandom); hi = 8'($urandom);
      rb = (($urandom % 2) == 0);
      re = (($urandom % 12) == 0);
      ra = (($urandom % 40) == 0);
      rr = (($urandom % 3) == 0);
      rs = 2'($urandom);
      step(rb, re, ra, rr, rs, 8'($urandom), "");
    end

    finish_run();
  end
endmodule